// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the hardwired control unit of a multicycle processor core that has one shared memory for instructions and data. Each instruction runs through a fixed series of encoded states. A common fetch cycle is followed by a common decode cycle, and then by a path specific to the instruction class: register-register arithmetic, OR with an immediate, load word, store word, or branch on equal. Every path ends by returning to fetch. In every state the block drives the datapath's steering and write-enable lines as combinational functions of the current state. Its only inputs are the opcode held in the instruction register and the ALU's zero and overflow flags.

Two faults leave the normal flow. The first is an opcode that matches no supported class, which is seen at decode. The second is an arithmetic overflow during the register-register execute cycle. In either case the sequencer spends one cycle in an exception state. In that cycle it uses the ALU to compute PC minus 4 and captures the result in the exception PC register. It also writes a cause code and loads the PC from a fixed handler address, which the block presents on a port. A register-register instruction that overflows never writes its result back.

The datapath uses `pc_we` as its final PC load enable. This output merges the unconditional PC write with the branch write, which is qualified by the zero flag.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: Reset is synchronous and active high. While `rst` is high, `pc_wr`, `pc_wr_cond`, `pc_we`, `ir_wr`, `mem_rd`, `mem_wr`, `reg_wr`, `epc_wr` and `cause_wr` are all 0. The first cycle after `rst` falls is a fetch cycle.
- R2: A fetch cycle asserts `mem_rd` and `ir_wr` with `addr_sel`=0 (PC). It also asserts `pc_wr` with `pc_src`=00 (ALU result) and sets `alu_sel_a`=0 (PC), `alu_sel_b`=001 (constant 4) and `alu_op`=00 (add). All other enables are 0.
- R3: The cycle after fetch is decode. Decode sets `alu_sel_a`=0, `alu_sel_b`=011 (sign-extended immediate shifted left 2) and `alu_op`=00, with every enable 0. Decode then dispatches on `opcode`: 0x00 register-register, 0x23 load, 0x2B store, 0x04 branch, 0x0D OR-immediate.
- R4: Register-register takes 4 cycles. Its execute cycle sets `alu_sel_a`=1 (register A), `alu_sel_b`=000 (register B) and `alu_op`=10 (function field). Its write-back cycle sets `reg_wr`=1, `reg_dst`=1 (rd field) and `mem_to_reg`=0.
- R5: OR-immediate takes 4 cycles. Its execute cycle sets `alu_sel_a`=1, `alu_sel_b`=100 (zero-extended immediate) and `alu_op`=11 (OR). Its write-back cycle sets `reg_wr`=1, `reg_dst`=0 (rt field) and `mem_to_reg`=0.
- R6: Load takes 5 cycles. The address cycle sets `alu_sel_a`=1, `alu_sel_b`=010 (sign-extended immediate) and `alu_op`=00. The read cycle sets `mem_rd`=1 and `addr_sel`=1 (ALU output register). The write-back cycle sets `reg_wr`=1, `reg_dst`=0 and `mem_to_reg`=1.
- R7: Store takes 4 cycles. It uses the same address cycle as load, followed by a cycle with `mem_wr`=1 and `addr_sel`=1. No cycle ever asserts more than one of `mem_wr`, `reg_wr` and `epc_wr`.
- R8: Branch takes 3 cycles. Its compare cycle sets `alu_sel_a`=1, `alu_sel_b`=000, `alu_op`=01 (subtract), `pc_wr_cond`=1 and `pc_src`=01 (ALU output register). In that cycle `pc_we` equals `alu_zero`.
- R9: Any other opcode leads from decode to one exception cycle. That cycle sets `epc_wr`=1, `cause_wr`=1 and `cause_code`=10. It also sets `alu_sel_a`=0, `alu_sel_b`=001 and `alu_op`=01 (PC minus 4), with `pc_wr`=1 and `pc_src`=10 (handler address). The next cycle is fetch.
- R10: If `alu_ovf` is 1 in a register-register execute cycle, the next cycle is the exception cycle with `cause_code`=12 in place of write-back, so `reg_wr` stays 0. The cycle after that is fetch.
- R11: `alu_ovf` has no effect in any cycle other than the register-register execute cycle. Load, store and OR-immediate keep their normal sequences with overflow held high.
- R12: `exc_vector` carries the handler address parameter, 0x8000_0080 by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field of the instruction register |
| alu_zero | input | 1 | ALU result is zero |
| alu_ovf | input | 1 | ALU signed overflow |
| pc_wr | output | 1 | Unconditional PC write |
| pc_wr_cond | output | 1 | PC write if zero flag set |
| pc_we | output | 1 | Effective PC load enable |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU output register, 10 handler |
| ir_wr | output | 1 | Instruction register write |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| addr_sel | output | 1 | Memory address: 0 PC, 1 ALU output register |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Destination: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Write data: 0 ALU output register, 1 memory data |
| alu_sel_a | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_sel_b | output | 3 | ALU operand B select |
| alu_op | output | 2 | ALU operation |
| epc_wr | output | 1 | Exception PC register write |
| cause_wr | output | 1 | Cause register write |
| cause_code | output | 5 | Exception code to store |
| exc_vector | output | 32 | Handler address |

## Verification
The bench builds the block with the default handler address of 0x8000_0080 and a 32-bit address width. The reference model therefore predicts the vector that a datapath of that width would load. Each class is run with the zero and overflow flags held at both values, which covers taken and untaken branches, the overflow detour, and the overflow flag being ignored on the load, store and OR-immediate paths. A reset pulse in the middle of a load shows that the sequencer leaves a partial instruction cleanly.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

    localparam int OPC_W   = 6;
    localparam int CAUSE_W = 5;

    localparam logic [OPC_W-1:0] OPC_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OPC_LOAD  = 6'h23;
    localparam logic [OPC_W-1:0] OPC_STORE = 6'h2B;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'h0D;

    localparam logic [CAUSE_W-1:0] CAUSE_UNDEF = CAUSE_W'(10);
    localparam logic [CAUSE_W-1:0] CAUSE_OVF   = CAUSE_W'(12);

    typedef enum logic [3:0] {
        ST_FETCH    = 4'b0000,
        ST_DECODE   = 4'b0001,
        ST_BRANCH   = 4'b0010,
        ST_MEM_ADDR = 4'b0011,
        ST_LD_READ  = 4'b0100,
        ST_LD_WB    = 4'b0101,
        ST_ST_WRITE = 4'b0110,
        ST_RR_EXEC  = 4'b0111,
        ST_RR_WB    = 4'b1000,
        ST_ORI_EXEC = 4'b1001,
        ST_ORI_WB   = 4'b1010,
        ST_EXC_UND  = 4'b1011,
        ST_EXC_OVF  = 4'b1100
    } state_e;

    typedef enum logic [2:0] {
        CLS_RTYPE, CLS_LOAD, CLS_STORE, CLS_BEQ, CLS_ORI, CLS_UNDEF
    } iclass_e;

    typedef enum logic [1:0] {
        ALU_ADD = 2'b00, ALU_SUB = 2'b01, ALU_FUNCT = 2'b10, ALU_OR = 2'b11
    } aluop_e;

    typedef enum logic [2:0] {
        SRCB_REG  = 3'b000, SRCB_FOUR = 3'b001, SRCB_SEXT = 3'b010,
        SRCB_SEXT_SH2 = 3'b011, SRCB_ZEXT = 3'b100
    } srcb_e;

    typedef enum logic [1:0] {
        PCSRC_ALU = 2'b00, PCSRC_ALUOUT = 2'b01, PCSRC_VECTOR = 2'b10
    } pcsrc_e;

    typedef struct packed {
        logic                pc_wr;
        logic                pc_wr_cond;
        pcsrc_e              pc_src;
        logic                ir_wr;
        logic                mem_rd;
        logic                mem_wr;
        logic                addr_sel;
        logic                reg_wr;
        logic                reg_dst;
        logic                mem_to_reg;
        logic                alu_sel_a;
        srcb_e               alu_sel_b;
        aluop_e              alu_op;
        logic                epc_wr;
        logic                cause_wr;
        logic [CAUSE_W-1:0]  cause_code;
    } ctrl_t;

    function automatic ctrl_t quiet_ctrl(input ctrl_t c);
        ctrl_t q;
        q            = c;
        q.pc_wr      = 1'b0;
        q.pc_wr_cond = 1'b0;
        q.ir_wr      = 1'b0;
        q.mem_rd     = 1'b0;
        q.mem_wr     = 1'b0;
        q.reg_wr     = 1'b0;
        q.epc_wr     = 1'b0;
        q.cause_wr   = 1'b0;
        return q;
    endfunction

endpackage

// File: rtl/mc_opclass.sv
module mc_opclass
    import mc_ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output iclass_e          cls
);
    always_comb begin
        unique case (opcode)
            OPC_RTYPE: cls = CLS_RTYPE;
            OPC_LOAD:  cls = CLS_LOAD;
            OPC_STORE: cls = CLS_STORE;
            OPC_BEQ:   cls = CLS_BEQ;
            OPC_ORI:   cls = CLS_ORI;
            default:   cls = CLS_UNDEF;
        endcase
    end
endmodule

// File: rtl/mc_next_state.sv
module mc_next_state
    import mc_ctrl_pkg::*;
(
    input  state_e  cur,
    input  iclass_e cls,
    input  logic    ovf,
    output state_e  nxt
);
    always_comb begin
        nxt = ST_FETCH;
        case (cur)
            ST_FETCH:  nxt = ST_DECODE;
            ST_DECODE: begin
                case (cls)
                    CLS_RTYPE:           nxt = ST_RR_EXEC;
                    CLS_ORI:             nxt = ST_ORI_EXEC;
                    CLS_LOAD, CLS_STORE: nxt = ST_MEM_ADDR;
                    CLS_BEQ:             nxt = ST_BRANCH;
                    default:             nxt = ST_EXC_UND;
                endcase
            end
            ST_MEM_ADDR: nxt = (cls == CLS_LOAD) ? ST_LD_READ : ST_ST_WRITE;
            ST_LD_READ:  nxt = ST_LD_WB;
            ST_RR_EXEC:  nxt = ovf ? ST_EXC_OVF : ST_RR_WB;
            ST_ORI_EXEC: nxt = ST_ORI_WB;
            default:     nxt = ST_FETCH;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
    import mc_ctrl_pkg::*;
(
    input  state_e cur,
    output ctrl_t  ctrl
);
    always_comb begin
        ctrl = '0;
        case (cur)
            ST_FETCH: begin
                ctrl.mem_rd    = 1'b1;
                ctrl.ir_wr     = 1'b1;
                ctrl.alu_sel_b = SRCB_FOUR;
                ctrl.alu_op    = ALU_ADD;
                ctrl.pc_src    = PCSRC_ALU;
                ctrl.pc_wr     = 1'b1;
            end
            ST_DECODE: begin
                ctrl.alu_sel_b = SRCB_SEXT_SH2;
                ctrl.alu_op    = ALU_ADD;
            end
            ST_BRANCH: begin
                ctrl.alu_sel_a  = 1'b1;
                ctrl.alu_sel_b  = SRCB_REG;
                ctrl.alu_op     = ALU_SUB;
                ctrl.pc_wr_cond = 1'b1;
                ctrl.pc_src     = PCSRC_ALUOUT;
            end
            ST_MEM_ADDR: begin
                ctrl.alu_sel_a = 1'b1;
                ctrl.alu_sel_b = SRCB_SEXT;
                ctrl.alu_op    = ALU_ADD;
            end
            ST_LD_READ: begin
                ctrl.mem_rd   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_LD_WB: begin
                ctrl.reg_wr     = 1'b1;
                ctrl.mem_to_reg = 1'b1;
            end
            ST_ST_WRITE: begin
                ctrl.mem_wr   = 1'b1;
                ctrl.addr_sel = 1'b1;
            end
            ST_RR_EXEC: begin
                ctrl.alu_sel_a = 1'b1;
                ctrl.alu_sel_b = SRCB_REG;
                ctrl.alu_op    = ALU_FUNCT;
            end
            ST_RR_WB: begin
                ctrl.reg_wr  = 1'b1;
                ctrl.reg_dst = 1'b1;
            end
            ST_ORI_EXEC: begin
                ctrl.alu_sel_a = 1'b1;
                ctrl.alu_sel_b = SRCB_ZEXT;
                ctrl.alu_op    = ALU_OR;
            end
            ST_ORI_WB: begin
                ctrl.reg_wr = 1'b1;
            end
            ST_EXC_UND, ST_EXC_OVF: begin
                ctrl.alu_sel_b  = SRCB_FOUR;
                ctrl.alu_op     = ALU_SUB;
                ctrl.epc_wr     = 1'b1;
                ctrl.cause_wr   = 1'b1;
                ctrl.cause_code = (cur == ST_EXC_OVF) ? CAUSE_OVF : CAUSE_UNDEF;
                ctrl.pc_wr      = 1'b1;
                ctrl.pc_src     = PCSRC_VECTOR;
            end
            default: ctrl = '0;
        endcase
    end
endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
    import mc_ctrl_pkg::*;
#(
    parameter int                ADDR_W     = 32,
    parameter logic [ADDR_W-1:0] EXC_VECTOR = ADDR_W'(32'h8000_0080)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [OPC_W-1:0]   opcode,
    input  logic               alu_zero,
    input  logic               alu_ovf,
    output logic               pc_wr,
    output logic               pc_wr_cond,
    output logic               pc_we,
    output logic [1:0]         pc_src,
    output logic               ir_wr,
    output logic               mem_rd,
    output logic               mem_wr,
    output logic               addr_sel,
    output logic               reg_wr,
    output logic               reg_dst,
    output logic               mem_to_reg,
    output logic               alu_sel_a,
    output logic [2:0]         alu_sel_b,
    output logic [1:0]         alu_op,
    output logic               epc_wr,
    output logic               cause_wr,
    output logic [CAUSE_W-1:0] cause_code,
    output logic [ADDR_W-1:0]  exc_vector
);
    state_e  state_q;
    state_e  state_d;
    iclass_e cls;
    ctrl_t   ctrl_raw;
    ctrl_t   ctrl_o;

    mc_opclass u_opclass (
        .opcode (opcode),
        .cls    (cls)
    );

    mc_next_state u_next (
        .cur (state_q),
        .cls (cls),
        .ovf (alu_ovf),
        .nxt (state_d)
    );

    mc_ctrl_decode u_dec (
        .cur  (state_q),
        .ctrl (ctrl_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_FETCH;
        else     state_q <= state_d;
    end

    always_comb begin
        ctrl_o = rst ? quiet_ctrl(ctrl_raw) : ctrl_raw;
    end

    assign pc_wr      = ctrl_o.pc_wr;
    assign pc_wr_cond = ctrl_o.pc_wr_cond;
    assign pc_we      = ctrl_o.pc_wr | (ctrl_o.pc_wr_cond & alu_zero);
    assign pc_src     = ctrl_o.pc_src;
    assign ir_wr      = ctrl_o.ir_wr;
    assign mem_rd     = ctrl_o.mem_rd;
    assign mem_wr     = ctrl_o.mem_wr;
    assign addr_sel   = ctrl_o.addr_sel;
    assign reg_wr     = ctrl_o.reg_wr;
    assign reg_dst    = ctrl_o.reg_dst;
    assign mem_to_reg = ctrl_o.mem_to_reg;
    assign alu_sel_a  = ctrl_o.alu_sel_a;
    assign alu_sel_b  = ctrl_o.alu_sel_b;
    assign alu_op     = ctrl_o.alu_op;
    assign epc_wr     = ctrl_o.epc_wr;
    assign cause_wr   = ctrl_o.cause_wr;
    assign cause_code = ctrl_o.cause_code;
    assign exc_vector = EXC_VECTOR;
endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk (
    input logic       clk,
    input logic       rst,
    input logic       alu_zero,
    input logic       alu_ovf,
    input logic       pc_wr,
    input logic       pc_wr_cond,
    input logic       pc_we,
    input logic [1:0] pc_src,
    input logic       ir_wr,
    input logic       mem_rd,
    input logic       mem_wr,
    input logic       reg_wr,
    input logic       reg_dst,
    input logic       mem_to_reg,
    input logic [2:0] alu_sel_b,
    input logic [1:0] alu_op,
    input logic       epc_wr,
    input logic       cause_wr,
    input logic [4:0] cause_code
);
    always @(negedge clk) begin
        if (rst) begin
            assert_rst_quiet_R1: assert (!(pc_wr || pc_wr_cond || pc_we || ir_wr || mem_rd
                                          || mem_wr || reg_wr || epc_wr || cause_wr));
        end
    end

    assert_fetch_after_rst_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (ir_wr && mem_rd && pc_wr));

    assert_decode_follows_R3: assert property (@(posedge clk) disable iff (rst)
        ir_wr |=> (!ir_wr && alu_sel_b == 3'b011 && !pc_we));

    assert_branch_gate_R8: assert property (@(posedge clk) disable iff (rst)
        pc_wr_cond |-> (pc_src == 2'b01 && !pc_wr && pc_we == alu_zero));

    assert_no_ovf_wb_R10: assert property (@(posedge clk) disable iff (rst)
        (alu_op == 2'b10 && alu_ovf) |=> (cause_wr && cause_code == 5'd12 && !reg_wr));

    assert_exc_return_R9: assert property (@(posedge clk) disable iff (rst)
        cause_wr |=> ir_wr);

    assert_exc_pc_R9: assert property (@(posedge clk) disable iff (rst)
        cause_wr |-> (epc_wr && pc_wr && pc_src == 2'b10));

    assert_single_store_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({mem_wr, reg_wr, epc_wr}));

    assert_load_dest_R6: assert property (@(posedge clk) disable iff (rst)
        (reg_wr && mem_to_reg) |-> !reg_dst);
endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk chk_i (
    .clk        (clk),
    .rst        (rst),
    .alu_zero   (alu_zero),
    .alu_ovf    (alu_ovf),
    .pc_wr      (pc_wr),
    .pc_wr_cond (pc_wr_cond),
    .pc_we      (pc_we),
    .pc_src     (pc_src),
    .ir_wr      (ir_wr),
    .mem_rd     (mem_rd),
    .mem_wr     (mem_wr),
    .reg_wr     (reg_wr),
    .reg_dst    (reg_dst),
    .mem_to_reg (mem_to_reg),
    .alu_sel_b  (alu_sel_b),
    .alu_op     (alu_op),
    .epc_wr     (epc_wr),
    .cause_wr   (cause_wr),
    .cause_code (cause_code)
);

// File: tb/mc_ctrl_fsm_tb_top.sv
module mc_ctrl_fsm_tb_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  opcode = 6'h00;
    logic        alu_zero = 1'b0;
    logic        alu_ovf = 1'b0;
    logic        pc_wr, pc_wr_cond, pc_we, ir_wr, mem_rd, mem_wr, addr_sel;
    logic        reg_wr, reg_dst, mem_to_reg, alu_sel_a, epc_wr, cause_wr;
    logic [1:0]  pc_src, alu_op;
    logic [2:0]  alu_sel_b;
    logic [4:0]  cause_code;
    logic [31:0] exc_vector;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    logic [23:0] exp_q[$];
    bit          we_q[$];
    string       tag_q[$];

    always #(CLK_P/2) clk = ~clk;

    mc_ctrl_fsm dut_i (
        .clk(clk), .rst(rst), .opcode(opcode), .alu_zero(alu_zero), .alu_ovf(alu_ovf),
        .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_we(pc_we), .pc_src(pc_src),
        .ir_wr(ir_wr), .mem_rd(mem_rd), .mem_wr(mem_wr), .addr_sel(addr_sel),
        .reg_wr(reg_wr), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
        .alu_sel_a(alu_sel_a), .alu_sel_b(alu_sel_b), .alu_op(alu_op),
        .epc_wr(epc_wr), .cause_wr(cause_wr), .cause_code(cause_code),
        .exc_vector(exc_vector)
    );

    // Packs one cycle of expected controls in a fixed bench order.
    function automatic logic [23:0] cw(
        input bit pcw, input bit pcc, input logic [1:0] ps, input bit irw,
        input bit mrd, input bit mwr, input bit ad, input bit rw, input bit rd,
        input bit m2r, input bit sa, input logic [2:0] sb, input logic [1:0] op,
        input bit ew, input bit cwr, input logic [4:0] cc);
        return {pcw, pcc, ps, irw, mrd, mwr, ad, rw, rd, m2r, sa, sb, op, ew, cwr, cc};
    endfunction

    function automatic logic [23:0] actual();
        return {pc_wr, pc_wr_cond, pc_src, ir_wr, mem_rd, mem_wr, addr_sel, reg_wr,
                reg_dst, mem_to_reg, alu_sel_a, alu_sel_b, alu_op, epc_wr, cause_wr, cause_code};
    endfunction

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic push(input logic [23:0] w, input bit we, input string tag);
        exp_q.push_back(w);
        we_q.push_back(we);
        tag_q.push_back(tag);
    endtask

    // Reference model: expected per-cycle controls for one instruction.
    task automatic plan_instr(input logic [5:0] opc, input bit ovf, input bit zero);
        push(cw(1,0,2'b00,1,1,0,0,0,0,0,0,3'b001,2'b00,0,0,5'd0), 1'b1, "R2");
        push(cw(0,0,2'b00,0,0,0,0,0,0,0,0,3'b011,2'b00,0,0,5'd0), 1'b0, "R3");
        case (opc)
            6'h00: begin
                push(cw(0,0,2'b00,0,0,0,0,0,0,0,1,3'b000,2'b10,0,0,5'd0), 1'b0, "R4");
                if (ovf)
                    push(cw(1,0,2'b10,0,0,0,0,0,0,0,0,3'b001,2'b01,1,1,5'd12), 1'b1, "R10");
                else
                    push(cw(0,0,2'b00,0,0,0,0,1,1,0,0,3'b000,2'b00,0,0,5'd0), 1'b0, "R4");
            end
            6'h0D: begin
                push(cw(0,0,2'b00,0,0,0,0,0,0,0,1,3'b100,2'b11,0,0,5'd0), 1'b0, ovf ? "R11" : "R5");
                push(cw(0,0,2'b00,0,0,0,0,1,0,0,0,3'b000,2'b00,0,0,5'd0), 1'b0, ovf ? "R11" : "R5");
            end
            6'h23: begin
                push(cw(0,0,2'b00,0,0,0,0,0,0,0,1,3'b010,2'b00,0,0,5'd0), 1'b0, ovf ? "R11" : "R6");
                push(cw(0,0,2'b00,0,1,0,1,0,0,0,0,3'b000,2'b00,0,0,5'd0), 1'b0, ovf ? "R11" : "R6");
                push(cw(0,0,2'b00,0,0,0,0,1,0,1,0,3'b000,2'b00,0,0,5'd0), 1'b0, ovf ? "R11" : "R6");
            end
            6'h2B: begin
                push(cw(0,0,2'b00,0,0,0,0,0,0,0,1,3'b010,2'b00,0,0,5'd0), 1'b0, ovf ? "R11" : "R7");
                push(cw(0,0,2'b00,0,0,1,1,0,0,0,0,3'b000,2'b00,0,0,5'd0), 1'b0, ovf ? "R11" : "R7");
            end
            6'h04: push(cw(0,1,2'b01,0,0,0,0,0,0,0,1,3'b000,2'b01,0,0,5'd0), zero, "R8");
            default: push(cw(1,0,2'b10,0,0,0,0,0,0,0,0,3'b001,2'b01,1,1,5'd10), 1'b1, "R9");
        endcase
    endtask

    // Called at a falling edge; drains the queue one cycle per entry.
    task automatic run_q(input logic [5:0] opc, input bit ovf, input bit zero);
        while (exp_q.size() > 0) begin
            logic [23:0] e;
            bit          w;
            string       t;
            opcode   = opc;
            alu_ovf  = ovf;
            alu_zero = zero;
            #1;
            e = exp_q.pop_front();
            w = we_q.pop_front();
            t = tag_q.pop_front();
            check(actual() === e, t, "controls", 64'(actual()), 64'(e));
            check(pc_we === w, t, "pc_we", 64'(pc_we), 64'(w));
            @(negedge clk);
        end
    endtask

    task automatic do_instr(input logic [5:0] opc, input bit ovf, input bit zero);
        plan_instr(opc, ovf, zero);
        run_q(opc, ovf, zero);
    endtask

    task automatic check_quiet(input string tag);
        #1;
        check({pc_wr, pc_wr_cond, pc_we, ir_wr, mem_rd, mem_wr, reg_wr, epc_wr, cause_wr} === 9'd0,
              tag, "enables in reset",
              64'({pc_wr, pc_wr_cond, pc_we, ir_wr, mem_rd, mem_wr, reg_wr, epc_wr, cause_wr}), 64'd0);
    endtask

    initial begin
        repeat (3) begin
            @(negedge clk);
            check_quiet("R1");
        end
        rst = 1'b0;
        check(exc_vector === 32'h8000_0080, "R12", "exc_vector", 64'(exc_vector), 64'h8000_0080);
        do_instr(6'h00, 1'b0, 1'b0);   // register-register
        do_instr(6'h0D, 1'b0, 1'b1);   // OR-immediate
        do_instr(6'h23, 1'b0, 1'b0);   // load
        do_instr(6'h2B, 1'b0, 1'b0);   // store
        do_instr(6'h04, 1'b0, 1'b1);   // branch taken
        do_instr(6'h04, 1'b0, 1'b0);   // branch not taken
        do_instr(6'h3F, 1'b0, 1'b0);   // undefined
        do_instr(6'h02, 1'b1, 1'b0);   // undefined, flags high
        do_instr(6'h00, 1'b1, 1'b0);   // overflow detour
        do_instr(6'h23, 1'b1, 1'b1);   // overflow ignored R11
        do_instr(6'h2B, 1'b1, 1'b0);   // overflow ignored R11
        do_instr(6'h0D, 1'b1, 1'b0);   // overflow ignored R11
        do_instr(6'h00, 1'b0, 1'b1);   // normal after exception
        // reset in the middle of a load (during its read cycle) R1
        plan_instr(6'h23, 1'b0, 1'b0);
        void'(exp_q.pop_back()); void'(we_q.pop_back()); void'(tag_q.pop_back());
        void'(exp_q.pop_back()); void'(we_q.pop_back()); void'(tag_q.pop_back());
        run_q(6'h23, 1'b0, 1'b0);
        rst = 1'b1;
        check_quiet("R1");
        @(negedge clk);
        rst = 1'b0;
        do_instr(6'h04, 1'b0, 1'b1);   // fetch right after reset R1
        check(exc_vector === 32'h8000_0080, "R12", "exc_vector", 64'(exc_vector), 64'h8000_0080);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule